// File: doc/BRIEF.md
# Synchronous Master Serial Receiver

This block receives serial words while acting as the clock master of a half-duplex synchronous link. It generates a shift clock on its clock output, reads the data line once per bit and assembles words of 8 bits, or 9 bits when the extended-word option is on. Bits arrive least-significant first. The clock rate comes from a programmable divisor. The idle level of the clock output is selectable.

Software starts reception in one of two ways. It can request a single word, which the block clears by itself once that word has arrived. It can also hold a continuous enable, which receives words back to back until the enable is dropped. When both are active, the continuous enable decides. Finished words go to a data register, and a ninth bit goes to its own output. A completion flag, gated by an interrupt enable, tells the host that a word is waiting. If the host falls behind, an overrun flag stops further loads until software drops the continuous enable.

Top module: `sync_rx_master`

## Requirements
- R1: While `port_en_i` is low, the clock output stays at its idle level and no word is received, whatever the receive enables are.
- R2: A pulse on `single_set_i` while the port is enabled sets `single_pend_o` one cycle later. Exactly one word is then received. `single_pend_o` clears in the same cycle the word completes, and the clock returns to idle.
- R3: With `cont_en_i` held, words follow back to back, with the next word's first active half starting right after the last bit's idle half. Dropping `cont_en_i` (with no single request pending) aborts the word in progress, and the clock is idle in the next cycle.
- R4: When the single request and `cont_en_i` are both active, continuous reception wins. The single request is used up by the first word, and reception goes on with the following words.
- R5: Each bit is sampled at the end of the clock's active half, which is the falling edge when the idle level is low. Bit 0 is received first, and received bit k lands in bit k of the word.
- R6: The idle level of `sclk_o` equals `idle_high_i`. Each bit period starts with a half at the opposite (active) level.
- R7: With `nine_bit_i` high, a word has 9 bits: bits 7..0 go to `rx_data_o` and bit 8 goes to `rx_bit8_o`. With it low, a word has 8 bits and `rx_bit8_o` is loaded with 0.
- R8: `rx_done_o` rises in the cycle a word is loaded. `irq_o` equals `rx_done_o` AND `rx_ie_i`. A one-cycle `rd_i` pulse clears `rx_done_o`.
- R9: Each clock half lasts D+1 cycles. D is `div_i` when `wide_div_i` is high, and `div_i[7:0]` (upper byte ignored) when it is low.
- R10: A word that completes while `rx_done_o` is set and `rd_i` is low is discarded. If `cont_en_i` is high, `overrun_o` also sets. While `overrun_o` is set, no word is loaded. `overrun_o` clears in the cycle after `cont_en_i` is low.
- R11: After reset, `sclk_o`, `rx_data_o`, `rx_bit8_o`, `rx_done_o`, `overrun_o`, `irq_o` and `single_pend_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset |
| port_en_i | input | 1 | Enables the port as synchronous master |
| cont_en_i | input | 1 | Continuous receive enable (level) |
| single_set_i | input | 1 | Pulse that requests one word |
| idle_high_i | input | 1 | Clock idle level select |
| nine_bit_i | input | 1 | Selects 9-bit words |
| wide_div_i | input | 1 | Selects the full-width divisor |
| div_i | input | DIV_W | Divisor, high and low bytes |
| rx_ie_i | input | 1 | Receive interrupt enable |
| rd_i | input | 1 | Data register read strobe |
| sdata_i | input | 1 | Serial data line |
| sclk_o | output | 1 | Shift clock driven to the link |
| single_pend_o | output | 1 | Single-word request pending |
| rx_data_o | output | DATA_W | Received data register |
| rx_bit8_o | output | 1 | Ninth received bit |
| rx_done_o | output | 1 | Receive-complete flag |
| overrun_o | output | 1 | Overrun error flag |
| irq_o | output | 1 | Receive interrupt |

## Verification
Single words are received with different divisors, polarities and widths. An 8-bit idle-low word at a short divisor checks bit order. A 9-bit idle-high word with a nonzero upper divisor byte shows whether the narrow divisor really ignores the upper byte and whether the ninth bit is routed correctly. A long full-width divisor checks that the upper byte takes effect. The data line carries the inverse of each bit during the idle half of its period, so sampling on the wrong clock edge produces wrong words. Continuous runs are tried three ways: read on time, left unread so that overrun must set and freeze the register, and started together with a single request to check which enable wins. A second single word left unread checks that it is discarded without raising overrun.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
   // Index of the final bit of a word; base width plus an optional extra bit
   function automatic int unsigned final_bit(input logic nine, input int unsigned base_w);
      return nine ? base_w : base_w - 1;
   endfunction
endpackage

// File: rtl/srx_clk_gen.sv
module srx_clk_gen #(
   parameter int unsigned DIV_W    = 16,
   parameter int unsigned DIV_LO_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             go_i,
   input  logic             wide_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             ck_o,
   output logic             start_o,
   output logic             smp_o
);
   localparam int unsigned PAD_W = DIV_W - DIV_LO_W;

   if (DIV_LO_W == 0 || DIV_LO_W > DIV_W) begin : g_bad_div
      $error("srx_clk_gen: DIV_LO_W must be in 1..DIV_W");
   end

   logic [DIV_W-1:0] reload;
   logic [DIV_W-1:0] cnt_q;
   logic             ck_q, busy_q;

   if (DIV_LO_W < DIV_W) begin : g_sel
      assign reload = wide_i ? div_i : {{PAD_W{1'b0}}, div_i[DIV_LO_W-1:0]};
   end else begin : g_full
      assign reload = div_i;
   end

   assign ck_o    = ck_q;
   assign start_o = !busy_q && go_i;
   assign smp_o   = busy_q && go_i && (cnt_q == '0) && ck_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_q <= 1'b0;
         ck_q   <= 1'b0;
         cnt_q  <= '0;
      end else if (!busy_q) begin
         if (go_i) begin
            busy_q <= 1'b1;
            ck_q   <= 1'b1;
            cnt_q  <= reload;
         end
      end else if (!go_i) begin
         busy_q <= 1'b0;
         ck_q   <= 1'b0;
         cnt_q  <= '0;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end else begin
         cnt_q <= reload;
         ck_q  <= !ck_q;
      end
   end

   // R9
   half_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_q && $past(busy_q) && (ck_q != $past(ck_q)) |-> $past(cnt_q) == '0);

   // R6
   idle_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_q |-> !ck_q);
endmodule

// File: rtl/srx_shifter.sv
module srx_shifter #(
   parameter int unsigned DATA_W = 8
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            start_i,
   input  logic            smp_i,
   input  logic            nine_i,
   input  logic            sdata_i,
   output logic            fire_o,
   output logic [DATA_W:0] word_o
);
   localparam int unsigned WORD_W = DATA_W + 1;
   localparam int unsigned IDX_W  = $clog2(WORD_W);

   logic [IDX_W-1:0]  bitn_q, last_idx;
   logic [WORD_W-1:0] shreg_q;

   assign last_idx = IDX_W'(sync_rx_pkg::final_bit(nine_i, DATA_W));
   assign fire_o   = smp_i && (bitn_q == last_idx);

   always_comb begin
      word_o         = shreg_q;
      word_o[bitn_q] = sdata_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         bitn_q  <= '0;
         shreg_q <= '0;
      end else if (start_i) begin
         bitn_q <= '0;
      end else if (smp_i) begin
         shreg_q <= word_o;
         bitn_q  <= fire_o ? '0 : bitn_q + 1'b1;
      end
   end

   // R5
   bit_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bitn_q <= IDX_W'(DATA_W));
endmodule

// File: rtl/srx_host_regs.sv
module srx_host_regs #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              port_en_i,
   input  logic              cont_en_i,
   input  logic              single_set_i,
   input  logic              nine_i,
   input  logic              rx_ie_i,
   input  logic              rd_i,
   input  logic              fire_i,
   input  logic [DATA_W:0]   word_i,
   output logic              single_o,
   output logic [DATA_W-1:0] data_o,
   output logic              bit8_o,
   output logic              done_o,
   output logic              ovr_o,
   output logic              irq_o
);
   logic              single_q, done_q, ovr_q, b8_q;
   logic [DATA_W-1:0] data_q;

   assign single_o = single_q;
   assign data_o   = data_q;
   assign bit8_o   = b8_q;
   assign done_o   = done_q;
   assign ovr_o    = ovr_q;
   assign irq_o    = done_q && rx_ie_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         single_q <= 1'b0;
      end else if (!port_en_i || fire_i) begin
         single_q <= 1'b0;
      end else if (single_set_i) begin
         single_q <= 1'b1;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         done_q <= 1'b0;
         ovr_q  <= 1'b0;
         b8_q   <= 1'b0;
         data_q <= '0;
      end else begin
         if (rd_i) done_q <= 1'b0;
         if (fire_i && !ovr_q) begin
            if (done_q && !rd_i) begin
               if (cont_en_i) ovr_q <= 1'b1;
            end else begin
               data_q <= word_i[DATA_W-1:0];
               b8_q   <= nine_i && word_i[DATA_W];
               done_q <= 1'b1;
            end
         end
         if (!cont_en_i) ovr_q <= 1'b0;
      end
   end

   // R2
   single_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire_i |=> !single_q);

   // R10
   ovr_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovr_q |=> $stable(data_q));

   // R10
   ovr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cont_en_i |=> !ovr_q);

   // R8
   done_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(done_q) |-> $past(fire_i));
endmodule

// File: rtl/sync_rx_master.sv
module sync_rx_master #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned DIV_W    = 16,
   parameter int unsigned DIV_LO_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              port_en_i,
   input  logic              cont_en_i,
   input  logic              single_set_i,
   input  logic              idle_high_i,
   input  logic              nine_bit_i,
   input  logic              wide_div_i,
   input  logic [DIV_W-1:0]  div_i,
   input  logic              rx_ie_i,
   input  logic              rd_i,
   input  logic              sdata_i,
   output logic              sclk_o,
   output logic              single_pend_o,
   output logic [DATA_W-1:0] rx_data_o,
   output logic              rx_bit8_o,
   output logic              rx_done_o,
   output logic              overrun_o,
   output logic              irq_o
);
   if (DATA_W < 2 || DATA_W > 15) begin : g_bad_width
      $error("sync_rx_master: DATA_W must be in 2..15");
   end

   logic            go, ck, start, smp, fire, single_q;
   logic [DATA_W:0] word;

   assign go     = port_en_i && (cont_en_i || single_q);
   assign sclk_o = ck ^ idle_high_i;
   assign single_pend_o = single_q;

   srx_clk_gen #(.DIV_W(DIV_W), .DIV_LO_W(DIV_LO_W)) u_clk (
      .clk_i(clk_i), .rst_ni(rst_ni), .go_i(go), .wide_i(wide_div_i),
      .div_i(div_i), .ck_o(ck), .start_o(start), .smp_o(smp)
   );

   srx_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .smp_i(smp),
      .nine_i(nine_bit_i), .sdata_i(sdata_i), .fire_o(fire), .word_o(word)
   );

   srx_host_regs #(.DATA_W(DATA_W)) u_regs (
      .clk_i(clk_i), .rst_ni(rst_ni), .port_en_i(port_en_i),
      .cont_en_i(cont_en_i), .single_set_i(single_set_i), .nine_i(nine_bit_i),
      .rx_ie_i(rx_ie_i), .rd_i(rd_i), .fire_i(fire), .word_i(word),
      .single_o(single_q), .data_o(rx_data_o), .bit8_o(rx_bit8_o),
      .done_o(rx_done_o), .ovr_o(overrun_o), .irq_o(irq_o)
   );

   // R1
   port_off_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !port_en_i |=> !ck);
endmodule

// File: tb/test_sync_rx_master.sv
`timescale 1ns/1ps
module test_sync_rx_master;
   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n, port_en, cont_en, single_set, idle_high, nine, wide, rx_ie, rd, sdata;
   logic [15:0] div;
   logic sclk, single_pend, rx_bit8, rx_done, overrun, irq;
   logic [7:0] rx_data;

   sync_rx_master i_sync_rx_master (
      .clk_i(clk), .rst_ni(rst_n), .port_en_i(port_en), .cont_en_i(cont_en),
      .single_set_i(single_set), .idle_high_i(idle_high), .nine_bit_i(nine),
      .wide_div_i(wide), .div_i(div), .rx_ie_i(rx_ie), .rd_i(rd), .sdata_i(sdata),
      .sclk_o(sclk), .single_pend_o(single_pend), .rx_data_o(rx_data),
      .rx_bit8_o(rx_bit8), .rx_done_o(rx_done), .overrun_o(overrun), .irq_o(irq)
   );

   int nchk = 0, nerr = 0, cyc = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [8:0] pat(input int i);
      return {i[0], 8'(i * 91 + 165)};
   endfunction

   function automatic int half_len();
      return wide ? int'(div) + 1 : int'(div[7:0]) + 1;
   endfunction

   // Behavioural reference model, stepped on every rising edge
   bit m_busy, m_single, m_done, m_ovr, m_b8;
   bit [7:0] m_data;
   bit [8:0] m_word;
   int m_el, m_words;

   always @(posedge clk) begin
      bit go, fire, n_single, n_done, n_ovr;
      int h, ph, nb;
      if (!rst_n) begin
         m_busy = 0; m_single = 0; m_done = 0; m_ovr = 0; m_b8 = 0;
         m_data = 0; m_word = 0; m_el = 0; m_words = 0;
      end else begin
         h = half_len();
         nb = nine ? 9 : 8;
         go = port_en && (cont_en || m_single);
         fire = 0;
         if (!m_busy) begin
            if (go) begin m_busy = 1; m_el = 0; end
         end else if (!go) begin
            m_busy = 0;
         end else begin
            m_el++;
            if (m_el % h == 0) begin
               ph = m_el / h;
               if (ph % 2 == 1) begin
                  m_word[(ph - 1) / 2] = sdata;
                  if ((ph - 1) / 2 == nb - 1) fire = 1;
               end
               if (ph == 2 * nb) m_el = 0;
            end
         end
         n_single = m_single;
         if (!port_en || fire) n_single = 0;
         else if (single_set) n_single = 1;
         n_done = m_done;
         n_ovr = m_ovr;
         if (rd) n_done = 0;
         if (fire) begin
            m_words++;
            if (!m_ovr) begin
               if (m_done && !rd) begin
                  if (cont_en) n_ovr = 1;
               end else begin
                  m_data = m_word[7:0];
                  m_b8 = nine && m_word[8];
                  n_done = 1;
               end
            end
         end
         if (!cont_en) n_ovr = 0;
         m_single = n_single; m_done = n_done; m_ovr = n_ovr;
      end
   end

   // Data line driver: true bit in the active half, inverted in the idle half
   initial begin
      sdata = 1'b0;
      forever begin
         @(negedge clk);
         if (m_busy) begin
            int h, k;
            logic [8:0] p;
            h = half_len();
            k = m_el / (2 * h);
            p = pat(m_words);
            sdata = ((m_el / h) % 2 == 0) ? p[k] : ~p[k];
         end
      end
   end

   // Cycle-by-cycle comparison against the model
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n) begin
            int h;
            logic exp_ck;
            h = half_len();
            exp_ck = m_busy && ((m_el / h) % 2 == 0);
            chk("R6/R9 sclk_o", 32'(sclk), 32'(exp_ck ^ idle_high));
            chk("R2 single_pend_o", 32'(single_pend), 32'(m_single));
            chk("R5 rx_data_o", 32'(rx_data), 32'(m_data));
            chk("R7 rx_bit8_o", 32'(rx_bit8), 32'(m_b8));
            chk("R8 rx_done_o", 32'(rx_done), 32'(m_done));
            chk("R8 irq_o", 32'(irq), 32'(m_done && rx_ie));
            chk("R10 overrun_o", 32'(overrun), 32'(m_ovr));
         end
      end
   end

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wait_words(input int n);
      while (m_words < n) @(negedge clk);
   endtask

   task automatic wait_idle();
      while (m_busy) @(negedge clk);
   endtask

   task automatic pulse_rd();
      rd = 1'b1; @(negedge clk); rd = 1'b0;
   endtask

   task automatic pulse_single();
      single_set = 1'b1; @(negedge clk); single_set = 1'b0;
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000) begin
            nchk++; nerr++;
            $display("FAIL watchdog expired actual=hung expected=done");
            finish_run();
         end
      end
   end

   initial begin
      int w;
      rst_n = 0; port_en = 0; cont_en = 0; single_set = 0; idle_high = 0;
      nine = 0; wide = 0; rx_ie = 1; rd = 0; div = 16'd1;
      tick(5);
      rst_n = 1;
      @(negedge clk);
      // R11 reset state
      chk("R11 sclk", 32'(sclk), 0);
      chk("R11 data", 32'(rx_data), 0);
      chk("R11 done", 32'(rx_done), 0);
      chk("R11 ovr", 32'(overrun), 0);
      chk("R11 irq", 32'(irq), 0);
      chk("R11 single", 32'(single_pend), 0);
      chk("R11 bit8", 32'(rx_bit8), 0);

      // R1: enables with port disabled
      cont_en = 1;
      single_set = 1;
      tick(20);
      chk("R1 clock idle while port off", 32'(sclk), 0);
      chk("R1 no word while port off", 32'(rx_done), 0);
      chk("R1 single not armed while port off", 32'(single_pend), 0);
      cont_en = 0; single_set = 0;

      // R2/R5: single 8-bit word, idle low, D=1
      port_en = 1;
      w = m_words;
      pulse_single();
      chk("R2 single pending", 32'(single_pend), 1);
      wait_words(w + 1);
      tick(3);
      chk("R5 lsb-first word", 32'(rx_data), 32'(pat(w) & 9'h0FF));
      chk("R8 done set", 32'(rx_done), 1);
      chk("R8 irq set", 32'(irq), 1);
      chk("R2 single self-cleared", 32'(single_pend), 0);
      chk("R2 clock back idle", 32'(sclk), 0);
      chk("R2 exactly one word", 32'(m_words), 32'(w + 1));
      pulse_rd();
      chk("R8 read clears done", 32'(rx_done), 0);
      rx_ie = 0;

      // R6/R7/R9: idle high, 9-bit, narrow divisor with upper byte set
      idle_high = 1; nine = 1; div = 16'h0302;
      tick(2);
      chk("R6 idle high level", 32'(sclk), 1);
      w = m_words;
      pulse_single();
      tick(2);
      chk("R6 active half low", 32'(sclk), 0);
      wait_words(w + 1);
      tick(2);
      chk("R7 low byte of 9-bit word", 32'(rx_data), 32'(pat(w) & 9'h0FF));
      chk("R7 ninth bit", 32'(rx_bit8), 32'(pat(w) >> 8));
      chk("R8 irq masked", 32'(irq), 0);
      pulse_rd();
      wait_idle();

      // R9: full-width divisor, 8-bit, idle low
      idle_high = 0; nine = 0; wide = 1; div = 16'h0101; rx_ie = 1;
      w = m_words;
      pulse_single();
      tick(150);
      chk("R9 long half still active", 32'(sclk), 1);
      wait_words(w + 1);
      tick(2);
      chk("R9 word at long divisor", 32'(rx_data), 32'(pat(w) & 9'h0FF));
      chk("R7 bit8 zero in 8-bit mode", 32'(rx_bit8), 0);
      pulse_rd();
      wait_idle();

      // R3: continuous reception, read in time
      wide = 0; div = 16'd1;
      w = m_words;
      cont_en = 1;
      for (int i = 0; i < 3; i++) begin
         wait_words(w + i + 1);
         tick(1);
         chk("R3 continuous word", 32'(rx_data), 32'(pat(w + i) & 9'h0FF));
         pulse_rd();
      end
      tick(5);
      cont_en = 0;
      tick(2);
      chk("R3 abort idles clock", 32'(sclk), 0);
      chk("R3 no overrun on timely reads", 32'(overrun), 0);

      // R10: continuous reception without reads
      w = m_words;
      cont_en = 1;
      wait_words(w + 3);
      tick(2);
      chk("R10 overrun set", 32'(overrun), 1);
      chk("R10 first word kept", 32'(rx_data), 32'(pat(w) & 9'h0FF));
      pulse_rd();
      chk("R10 overrun survives read", 32'(overrun), 1);
      wait_words(m_words + 1);
      tick(2);
      chk("R10 no load while overrun", 32'(rx_done), 0);
      cont_en = 0;
      tick(2);
      chk("R10 overrun cleared", 32'(overrun), 0);

      // R4: both enables together
      w = m_words;
      cont_en = 1;
      pulse_single();
      wait_words(w + 3);
      tick(1);
      chk("R4 single consumed", 32'(single_pend), 0);
      chk("R4 reception continues", 32'(m_busy), 1);
      cont_en = 0;
      tick(2);
      pulse_rd();
      wait_idle();

      // R10: unread single word discarded without overrun
      w = m_words;
      pulse_single();
      wait_words(w + 1);
      tick(2);
      pulse_single();
      wait_words(w + 2);
      tick(2);
      chk("R10 unread word kept", 32'(rx_data), 32'(pat(w) & 9'h0FF));
      chk("R10 no overrun without continuous", 32'(overrun), 0);
      chk("R10 done still set", 32'(rx_done), 1);
      tick(4);
      finish_run();
   end
endmodule